// File: doc/BRIEF.md
# Word Memory with Split ROM, RAM and Empty Address Ranges

This block is a word-addressed memory for a small 16-bit processor. One 16-bit address space is cut into three ranges. The lowest range is a fixed program store whose words are computed inside the block. The range above it is read/write storage. Everything higher has no storage at all. A single write-enable pin turns the current cycle's access into a write. When it is low, the access is a read.

The address decoder finds the range that the current address falls in. It then sends a small set of strobes to a storage datapath, which holds the RAM array, produces the fixed words and muxes the read data. Reads are combinational and follow the address within the same cycle. Writes are committed on the rising clock edge, and only when the address is inside the writable range.

The range limits are parameters. `RomWords` sets the size of the fixed range and `RamTop` sets the last writable address. The full map ends the writable range at 0x3FFF. The default build ends it at 0x07FF so that the array stays small. The requirements are written in terms of the parameters and quote the default values.

Top module: `memmap_top`

## Requirements
- R1: An address below `RomWords` (default 256) reads a fixed word. The word at address a is {a[7:0] XOR 0xC3, bitwise NOT of a[7:0]}, with the upper byte in bits 15:8.
- R2: A rising clock edge with `wrEn` high and an address from `RomWords` to `RamTop` inclusive (default 0x0100 to 0x07FF) stores `wrData` at that address. A later read of that address returns the stored word.
- R3: Reads are combinational. In a write cycle, `rdData` shows the old word before the edge and the new word once the edge has passed.
- R4: Any address above `RamTop` reads as 0x0000.
- R5: A write to an address below `RomWords` is ignored, and the fixed words read back unchanged.
- R6: A write to an address above `RamTop` is ignored. No RAM word changes, including RAM words whose low address bits match the written address.
- R7: A clock edge with `wrEn` low changes no stored word.
- R8: The range edges decode exactly. `RomWords`-1 is fixed, `RomWords` is RAM, `RamTop` is RAM, and both `RamTop`+1 and 0xFFFF are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| addr | input | 16 | Word address |
| wrData | input | 16 | Data to store |
| wrEn | input | 1 | High: write this cycle; low: read |
| rdData | output | 16 | Word at `addr`, combinational |

## Verification
The bench fills every writable word and then reads all 65536 addresses. A decoder with an off-by-one limit would therefore misplace one of the edge addresses and return the wrong region's word. The bench also writes over the entire fixed range, which shows whether a design lets the RAM write path reach those addresses. Empty addresses whose low bits collide with RAM indices are written next. If the RAM index were taken from truncated address bits alone, those writes would corrupt live words. Finally, the bench checks `rdData` on both sides of a write edge, which catches a registered read or a write-through read.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int WordW   = 16;
  localparam int RomIdxW = 8;

  // strobes from the address decoder to the storage datapath
  typedef struct packed {
    logic romSel;
    logic ramSel;
    logic ramWe;
  } memStrobe_t;

  // fixed program-store contents, computed from the index
  function automatic logic [WordW-1:0] romWord(input logic [RomIdxW-1:0] idx);
    return {idx ^ 8'hC3, ~idx};
  endfunction
endpackage

// File: rtl/memmap_decode.sv
module memmap_decode
  import memmap_pkg::*;
#(
  parameter int AddrW    = 16,
  parameter int RomWords = 256,
  parameter int RamTop   = 16'h07FF,
  parameter int RamIdxW  = 11
) (
  input  logic [AddrW-1:0]   addr,
  input  logic               wrEn,
  output memStrobe_t         strobe,
  output logic [RomIdxW-1:0] romIdx,
  output logic [RamIdxW-1:0] ramIdx
);
  localparam logic [AddrW-1:0] RamBase = AddrW'(RomWords);
  localparam logic [AddrW-1:0] RamLast = AddrW'(RamTop);

  logic inRom;
  logic inRam;

  always_comb begin
    inRom = (addr < RamBase);
    inRam = !inRom && (addr <= RamLast);
    strobe.romSel = inRom;
    strobe.ramSel = inRam;
    strobe.ramWe  = inRam && wrEn;
    romIdx = addr[RomIdxW-1:0];
    ramIdx = RamIdxW'(addr - RamBase);
  end
endmodule

// File: rtl/memmap_store.sv
module memmap_store
  import memmap_pkg::*;
#(
  parameter int RamWords = 1792,
  parameter int RamIdxW  = 11
) (
  input  logic               clk,
  input  memStrobe_t         strobe,
  input  logic [RomIdxW-1:0] romIdx,
  input  logic [RamIdxW-1:0] ramIdx,
  input  logic [WordW-1:0]   wrData,
  output logic [WordW-1:0]   rdData
);
  logic [WordW-1:0] ramArr [RamWords];

  always_ff @(posedge clk) begin
    if (strobe.ramWe) ramArr[ramIdx] <= wrData;
  end

  always_comb begin
    rdData = '0;
    if (strobe.romSel)      rdData = romWord(romIdx);
    else if (strobe.ramSel) rdData = ramArr[ramIdx];
  end
endmodule

// File: rtl/memmap_top.sv
module memmap_top
  import memmap_pkg::*;
#(
  parameter int AddrW    = 16,
  parameter int RomWords = 256,
  parameter int RamTop   = 16'h07FF
) (
  input  logic             clk,
  input  logic [AddrW-1:0] addr,
  input  logic [WordW-1:0] wrData,
  input  logic             wrEn,
  output logic [WordW-1:0] rdData
);
  localparam int RamWords = RamTop - RomWords + 1;
  localparam int RamIdxW  = $clog2(RamWords);

  memStrobe_t         strobe;
  logic [RomIdxW-1:0] romIdx;
  logic [RamIdxW-1:0] ramIdx;

  memmap_decode #(
    .AddrW(AddrW), .RomWords(RomWords), .RamTop(RamTop), .RamIdxW(RamIdxW)
  ) u_decode (
    .addr(addr), .wrEn(wrEn), .strobe(strobe), .romIdx(romIdx), .ramIdx(ramIdx)
  );

  memmap_store #(
    .RamWords(RamWords), .RamIdxW(RamIdxW)
  ) u_store (
    .clk(clk), .strobe(strobe), .romIdx(romIdx), .ramIdx(ramIdx),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/memmap_checker.sv
module memmap_checker
  import memmap_pkg::*;
#(
  parameter int AddrW    = 16,
  parameter int RomWords = 256,
  parameter int RamTop   = 16'h07FF
) (
  input logic             clk,
  input logic [AddrW-1:0] addr,
  input logic [WordW-1:0] wrData,
  input logic             wrEn,
  input logic [WordW-1:0] rdData,
  input memStrobe_t       strobe
);
  localparam logic [AddrW-1:0] RamBase = AddrW'(RomWords);
  localparam logic [AddrW-1:0] RamLast = AddrW'(RamTop);

  logic             seen = 1'b0;
  logic [AddrW-1:0] pAddr;
  logic [WordW-1:0] pData;
  logic [WordW-1:0] pRd;
  logic             pWr;

  always_ff @(posedge clk) begin
    // checks use values from the previous edge only once one edge has passed
    if (seen && pWr && addr == pAddr && pAddr >= RamBase && pAddr <= RamLast)
      a_r2_ram_holds_written: assert (rdData == pData);
    if (seen && pAddr < RamBase && addr == pAddr)
      a_r5_rom_never_changes: assert (rdData == pRd);
    if (addr > RamLast)
      a_r4_empty_reads_zero: assert (rdData == '0);
    if (strobe.ramWe)
      a_r6_write_only_in_ram: assert (wrEn && addr >= RamBase && addr <= RamLast);
    a_r8_one_region: assert ($onehot0({strobe.romSel, strobe.ramSel}));
    seen  <= 1'b1;
    pAddr <= addr;
    pData <= wrData;
    pRd   <= rdData;
    pWr   <= wrEn;
  end
endmodule

bind memmap_top memmap_checker #(
  .AddrW(AddrW), .RomWords(RomWords), .RamTop(RamTop)
) u_chk (
  .clk(clk), .addr(addr), .wrData(wrData), .wrEn(wrEn),
  .rdData(rdData), .strobe(strobe)
);

// File: tb/test_memmap_top.sv
module test_memmap_top;
  localparam int ClkPeriod = 10;
  localparam int RomWords  = 256;
  localparam int RamTop    = 16'h07FF;

  logic        clk = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic [15:0] rdData;
  int          total = 0;
  int          fails = 0;
  bit          done = 1'b0;

  memmap_top i_memmap_top (
    .clk(clk), .addr(addr), .wrData(wrData), .wrEn(wrEn), .rdData(rdData)
  );

  always #(ClkPeriod/2) clk = ~clk;

  function automatic logic [15:0] ramPat(input int a);
    logic [15:0] x;
    x = a[15:0];
    return (x * 16'h9E37) ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] expRead(input int a);
    if (a < RomWords) return {a[7:0] ^ 8'hC3, ~a[7:0]};
    if (a <= RamTop) return ramPat(a);
    return 16'h0000;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s addr=%h got %h expected %h", tag, addr, got, exp);
    end
  endtask

  task automatic sweep(input int lo, input int hi, input string tag);
    for (int a = lo; a <= hi; a++) begin
      addr = a[15:0];
      #1;
      chk(tag, rdData, expRead(a));
    end
  endtask

  initial begin
    // start-up state: fixed words and empty space need no writes
    #1;
    chk("R1 start", rdData, 16'hC3FF);
    addr = 16'h4000; #1;
    chk("R4 start", rdData, 16'h0000);

    // R1 and R4 before RAM is filled
    @(negedge clk);
    sweep(0, RomWords - 1, "R1");
    sweep(RamTop + 1, 16'hFFFF, "R4");

    // R2: fill every RAM word, one per edge
    @(negedge clk);
    for (int a = RomWords; a <= RamTop; a++) begin
      addr = a[15:0]; wrData = ramPat(a); wrEn = 1'b1;
      @(negedge clk);
    end
    wrEn = 1'b0;
    sweep(0, 16'hFFFF, "R2");

    // R8: edge addresses
    addr = 16'(RomWords - 1); #1; chk("R8 last rom", rdData, expRead(RomWords - 1));
    addr = 16'(RomWords);     #1; chk("R8 first ram", rdData, ramPat(RomWords));
    addr = 16'(RamTop);       #1; chk("R8 last ram", rdData, ramPat(RamTop));
    addr = 16'(RamTop + 1);   #1; chk("R8 first empty", rdData, 16'h0000);
    addr = 16'hFFFF;          #1; chk("R8 top empty", rdData, 16'h0000);

    // R5: write over every fixed word
    @(negedge clk);
    for (int a = 0; a < RomWords; a++) begin
      addr = a[15:0]; wrData = 16'hFFFF; wrEn = 1'b1;
      @(negedge clk);
    end
    wrEn = 1'b0;
    sweep(0, RomWords - 1, "R5");
    sweep(RomWords, RamTop, "R5 ram");

    // R6: write to empty space, including addresses that alias RAM indices
    @(negedge clk);
    for (int a = RamTop + 1; a <= RamTop + 1 + 2048; a++) begin
      addr = a[15:0]; wrData = 16'hDEAD; wrEn = 1'b1;
      @(negedge clk);
    end
    for (int a = 16'h8000; a <= 16'hFFFF; a += 16'h0101) begin
      addr = a[15:0]; wrData = 16'hBEEF; wrEn = 1'b1;
      @(negedge clk);
    end
    addr = 16'hFFFF; wrData = 16'hBEEF; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    sweep(0, 16'hFFFF, "R6");

    // R7: edges with wrEn low over RAM
    @(negedge clk);
    for (int a = RomWords; a < RomWords + 64; a++) begin
      addr = a[15:0]; wrData = 16'h1111; wrEn = 1'b0;
      @(negedge clk);
    end
    sweep(RomWords, RamTop, "R7");

    // R3: old value before the edge, new value after it
    @(negedge clk);
    addr = 16'h0300; wrData = 16'hA5C3; wrEn = 1'b1;
    #1; chk("R3 before edge", rdData, ramPat(16'h0300));
    @(posedge clk); #1;
    chk("R3 after edge", rdData, 16'hA5C3);
    @(negedge clk);
    wrEn = 1'b0;
    #1; chk("R2 readback", rdData, 16'hA5C3);
    addr = 16'h0301; #1; chk("R2 neighbour", rdData, ramPat(16'h0301));

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(ClkPeriod * 150000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule